// File: doc/BRIEF.md
# Dithered NCO Down-Mixer

This block is the front of a digital down-conversion chain. For each valid real input sample it builds a local-oscillator phase, adds a small pseudo-random dither to the low phase bits, and truncates the result to a short phase word. A quarter-wave sine table turns that phase word into cosine and negated sine values. Two multipliers then produce complex baseband samples, rounded and clamped to the word size the next decimation stage expects.

The oscillator frequency is set by a 32-bit phase step that the accumulator adds once per accepted sample. A step of 894513835 places the oscillator at 14.44 MHz when the input runs at 69.333 Msamples/s. The dither breaks up the periodic phase-truncation error, which would otherwise show up as discrete spurs. The block has no flow control. Each accepted sample leaves the block as one output sample a fixed three cycles later.

Top module: `ddc_nco_mixer`

## Requirements
- R1: Synchronous active-high reset clears `out_valid`, `out_i` and `out_q` to 0, sets the accumulator to 0, and loads the 16-bit dither register with 0xACE1. The first sample after reset therefore uses phase 0 and the seed's dither.
- R2: A sample accepted at a rising edge (`in_valid` high) appears with `out_valid` high exactly three rising edges later. Back-to-back inputs give back-to-back outputs. `out_valid` is never high without a matching input.
- R3: The undithered phase of sample n is the sum of all earlier accepted increments, modulo 2^32. The first sample after reset has phase 0. The accumulator changes only on accepted samples, using the `phase_inc` present in that cycle.
- R4: The dither is the low 14 bits of a 16-bit shift register. On every accepted sample, after its value is used, the register shifts left and takes in the XOR of its bits 15, 13, 12 and 10 as the new bit 0. The dither is added to the 32-bit phase, wrapping at 2^32, and the sum's bits 31..14 form the 18-bit truncated phase.
- R5: In the truncated phase, bits 17..16 are the quadrant and bits 15..8 are the table index i. The table holds T[k] = 2^17·sin(kπ/512) for k = 0..256, each entry within one LSB. Sine is +T[i], +T[256−i], −T[i] or −T[256−i] for quadrants 0, 1, 2 and 3. Cosine is the sine value looked up with the quadrant plus one, modulo 4.
- R6: With the input x in Q18 and the table values in Q17, I = x·cos and Q = x·(−sin). Each product is taken to Q19 by adding 2^15 and then shifting right arithmetically by 16 bits.
- R7: A rounded result above 524287 is output as 524287. A result below −524288 is output as −524288. Example: x = −2^18 at a phase where sine is +1 gives Q = 524287.
- R8: While `in_valid` is low, the accumulator and dither register keep their values. `out_i` and `out_q` hold whenever `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input sample strobe |
| in_x | input | 19 | Signed real input sample, Q18 |
| phase_inc | input | 32 | Phase step added per accepted sample |
| out_valid | output | 1 | Output sample strobe |
| out_i | output | 20 | Signed in-phase output, Q19 |
| out_q | output | 20 | Signed quadrature output, Q19 |

## Verification
A quarter-turn phase step with full-scale negative input visits each quadrant boundary. It separates errors in quadrant folding, sign handling and saturation on both outputs. Long random runs at the default tuning and at random steps, some back-to-back and some with idle gaps, show whether the accumulator and dither register advance only on accepted samples. A step whose low 22 bits are all ones, given right after reset, makes the dither carry into the table index. That single sample is off by thousands of LSBs if the dither is missing or misplaced.

// File: rtl/nco_mix_pkg.sv
package nco_mix_pkg;

  localparam int unsigned DEF_ACC_W    = 32;
  localparam int unsigned DEF_PHASE_W  = 18;
  localparam int unsigned DEF_DITHER_W = 14;
  localparam int unsigned DEF_LFSR_W   = 16;
  localparam logic [15:0] DEF_LFSR_SEED = 16'hACE1;
  localparam logic [15:0] DEF_LFSR_TAPS = 16'hB400;  // bits 15,13,12,10

  // Step for 14.44 MHz at 69.333 Msamples/s
  localparam logic [31:0] TUNE_DEFAULT = 32'd894513835;

  typedef enum logic [1:0] {
    QD_RISE     = 2'd0,
    QD_FALL     = 2'd1,
    QD_NEG_RISE = 2'd2,
    QD_NEG_FALL = 2'd3
  } quadrant_e;

  // Elaboration-time sine of k*pi/(2*n_pts), scaled by 2^mag_w.
  // Odd Taylor series in Q30 integer arithmetic.
  function automatic longint quarter_sine_q(input int k, input int n_pts, input int mag_w);
    longint ang, ang2, term, sum;
    ang  = (longint'(k) * 64'sd3373259426) / longint'(2 * n_pts);
    ang2 = (ang * ang) >>> 30;
    term = ang;
    sum  = ang;
    for (int n = 1; n <= 8; n++) begin
      term = -(((term * ang2) >>> 30) / longint'((2 * n) * (2 * n + 1)));
      sum  = sum + term;
    end
    sum = ((sum <<< mag_w) + (64'sd1 <<< 29)) >>> 30;
    if (sum < 0) sum = 0;
    if (sum > (64'sd1 <<< mag_w)) sum = 64'sd1 <<< mag_w;
    return sum;
  endfunction

endpackage

// File: rtl/nco_dither_lfsr.sv
module nco_dither_lfsr #(
  parameter int unsigned      W    = 16,
  parameter logic [W-1:0]     SEED = 16'hACE1,
  parameter logic [W-1:0]     TAPS = 16'hB400
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         advance,
  output logic [W-1:0] state
);

  logic fb_bit;
  assign fb_bit = ^(state & TAPS);

  always_ff @(posedge clk) begin
    if (rst)          state <= SEED;
    else if (advance) state <= {state[W-2:0], fb_bit};
  end

  logic armed;
  always_ff @(posedge clk) armed <= !rst;

  assert_lfsr_alive_R4: assert property (@(posedge clk) disable iff (rst)
    state != '0);

  assert_lfsr_hold_R8: assert property (@(posedge clk) disable iff (rst)
    armed && !$past(advance) |-> $stable(state));

endmodule

// File: rtl/nco_phase_acc.sv
module nco_phase_acc #(
  parameter int unsigned ACC_W    = 32,
  parameter int unsigned PHASE_W  = 18,
  parameter int unsigned DITHER_W = 14
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  input  logic [ACC_W-1:0]    phase_inc,
  input  logic [DITHER_W-1:0] dither,
  output logic                ph_valid,
  output logic [PHASE_W-1:0]  ph_trunc
);

  logic [ACC_W-1:0] acc;
  logic [ACC_W-1:0] dithered;

  assign dithered = acc + ACC_W'(dither);

  always_ff @(posedge clk) begin
    if (rst) begin
      acc      <= '0;
      ph_valid <= 1'b0;
      ph_trunc <= '0;
    end else begin
      ph_valid <= in_valid;
      if (in_valid) begin
        acc      <= acc + phase_inc;
        ph_trunc <= dithered[ACC_W-1 -: PHASE_W];
      end
    end
  end

  logic armed;
  always_ff @(posedge clk) armed <= !rst;

  assert_acc_step_R3: assert property (@(posedge clk) disable iff (rst)
    armed && $past(in_valid) |-> acc == ACC_W'($past(acc) + $past(phase_inc)));

  assert_acc_hold_R8: assert property (@(posedge clk) disable iff (rst)
    armed && !$past(in_valid) |-> $stable(acc) && $stable(ph_trunc));

endmodule

// File: rtl/nco_sincos_lut.sv
module nco_sincos_lut
  import nco_mix_pkg::*;
#(
  parameter int unsigned PHASE_W = 18,
  parameter int unsigned TBL_W   = 8,
  parameter int unsigned MAG_W   = 17
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       in_valid,
  input  logic [PHASE_W-1:0]         phase,
  output logic                       lut_valid,
  output logic signed [MAG_W+1:0]    cos_o,
  output logic signed [MAG_W+1:0]    nsin_o
);

  localparam int unsigned NPTS   = 1 << TBL_W;
  localparam int unsigned AW     = TBL_W + 1;
  localparam int unsigned TRIG_W = MAG_W + 2;
  localparam logic signed [TRIG_W-1:0] FULL = TRIG_W'(1 << MAG_W);

  logic [MAG_W:0] qtab [NPTS+1];

  for (genvar k = 0; k <= NPTS; k++) begin : g_tab
    localparam logic [MAG_W:0] ENTRY = (MAG_W+1)'(quarter_sine_q(k, NPTS, MAG_W));
    assign qtab[k] = ENTRY;
  end

  logic [1:0]       quad_s, quad_c;
  logic [TBL_W-1:0] idx;
  logic [AW-1:0]    rise_idx, fall_idx;
  logic [MAG_W:0]   mag_rise, mag_fall;

  assign quad_s   = phase[PHASE_W-1 -: 2];
  assign quad_c   = quad_s + 2'd1;
  assign idx      = phase[PHASE_W-3 -: TBL_W];
  assign rise_idx = {1'b0, idx};
  assign fall_idx = AW'(NPTS) - rise_idx;
  assign mag_rise = qtab[rise_idx];
  assign mag_fall = qtab[fall_idx];

  function automatic logic signed [TRIG_W-1:0] fold(input logic [1:0] quad,
                                                    input logic [MAG_W:0] rise,
                                                    input logic [MAG_W:0] fall);
    logic signed [TRIG_W-1:0] r, f;
    r = $signed({1'b0, rise});
    f = $signed({1'b0, fall});
    case (quadrant_e'(quad))
      QD_RISE:     return r;
      QD_FALL:     return f;
      QD_NEG_RISE: return -r;
      default:     return -f;
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      lut_valid <= 1'b0;
      cos_o     <= '0;
      nsin_o    <= '0;
    end else begin
      lut_valid <= in_valid;
      if (in_valid) begin
        cos_o  <= fold(quad_c, mag_rise, mag_fall);
        nsin_o <= -fold(quad_s, mag_rise, mag_fall);
      end
    end
  end

  logic armed;
  always_ff @(posedge clk) armed <= !rst;

  assert_trig_bound_R5: assert property (@(posedge clk) disable iff (rst)
    lut_valid |-> cos_o <= FULL && cos_o >= -FULL && nsin_o <= FULL && nsin_o >= -FULL);

  assert_zero_axis_R5: assert property (@(posedge clk) disable iff (rst)
    armed && $past(in_valid && phase[PHASE_W-1 -: AW+1] == '0) |-> cos_o == FULL && nsin_o == '0);

endmodule

// File: rtl/nco_cplx_mult.sv
module nco_cplx_mult #(
  parameter int unsigned IN_W   = 19,
  parameter int unsigned TRIG_W = 19,
  parameter int unsigned OUT_W  = 20,
  parameter int unsigned SHIFT  = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     in_valid,
  input  logic signed [IN_W-1:0]   x,
  input  logic signed [TRIG_W-1:0] cos_v,
  input  logic signed [TRIG_W-1:0] nsin_v,
  output logic                     out_valid,
  output logic signed [OUT_W-1:0]  out_i,
  output logic signed [OUT_W-1:0]  out_q
);

  localparam int unsigned PW = IN_W + TRIG_W;
  localparam logic signed [PW:0] OMAX  = $signed({{(PW+2-OUT_W){1'b0}}, {(OUT_W-1){1'b1}}});
  localparam logic signed [PW:0] OMIN  = ~OMAX;
  localparam logic signed [PW:0] RBIAS = $signed({{(PW+1-SHIFT){1'b0}}, 1'b1, {(SHIFT-1){1'b0}}});

  function automatic logic signed [PW:0] scale_round(input logic signed [PW-1:0] p);
    return ($signed({p[PW-1], p}) + RBIAS) >>> SHIFT;
  endfunction

  function automatic logic signed [OUT_W-1:0] clamp(input logic signed [PW:0] w);
    if (w > OMAX) return OMAX[OUT_W-1:0];
    if (w < OMIN) return OMIN[OUT_W-1:0];
    return w[OUT_W-1:0];
  endfunction

  logic signed [PW-1:0] prod_i, prod_q;
  logic signed [PW:0]   i_wide, q_wide;
  logic                 i_over, i_under, q_over, q_under;

  assign prod_i  = x * cos_v;
  assign prod_q  = x * nsin_v;
  assign i_wide  = scale_round(prod_i);
  assign q_wide  = scale_round(prod_q);
  assign i_over  = i_wide > OMAX;
  assign i_under = i_wide < OMIN;
  assign q_over  = q_wide > OMAX;
  assign q_under = q_wide < OMIN;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_i     <= '0;
      out_q     <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_i <= clamp(i_wide);
        out_q <= clamp(q_wide);
      end
    end
  end

  logic armed;
  always_ff @(posedge clk) armed <= !rst;

  assert_sat_high_R7: assert property (@(posedge clk) disable iff (rst)
    armed && $past(in_valid && (i_over || q_over)) |->
      ($past(i_over) ? out_i == OMAX[OUT_W-1:0] : out_q == OMAX[OUT_W-1:0]));

  assert_sat_low_R7: assert property (@(posedge clk) disable iff (rst)
    armed && $past(in_valid && (i_under || q_under)) |->
      ($past(i_under) ? out_i == OMIN[OUT_W-1:0] : out_q == OMIN[OUT_W-1:0]));

  assert_out_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> $stable(out_i) && $stable(out_q));

endmodule

// File: rtl/ddc_nco_mixer.sv
module ddc_nco_mixer
  import nco_mix_pkg::*;
#(
  parameter int unsigned        ACC_W     = DEF_ACC_W,
  parameter int unsigned        PHASE_W   = DEF_PHASE_W,
  parameter int unsigned        DITHER_W  = DEF_DITHER_W,
  parameter int unsigned        LFSR_W    = DEF_LFSR_W,
  parameter logic [LFSR_W-1:0]  LFSR_SEED = LFSR_W'(DEF_LFSR_SEED),
  parameter logic [LFSR_W-1:0]  LFSR_TAPS = LFSR_W'(DEF_LFSR_TAPS),
  parameter int unsigned        IN_W      = 19,
  parameter int unsigned        IN_FRAC   = 18,
  parameter int unsigned        TBL_W     = 8,
  parameter int unsigned        MAG_W     = 17,
  parameter int unsigned        OUT_W     = 20,
  parameter int unsigned        OUT_FRAC  = 19
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  input  logic signed [IN_W-1:0]  in_x,
  input  logic [ACC_W-1:0]        phase_inc,
  output logic                    out_valid,
  output logic signed [OUT_W-1:0] out_i,
  output logic signed [OUT_W-1:0] out_q
);

  localparam int unsigned TRIG_W  = MAG_W + 2;
  localparam int unsigned SHIFT   = IN_FRAC + MAG_W - OUT_FRAC;
  localparam int unsigned LATENCY = 3;

  logic [LFSR_W-1:0]         lfsr_state;
  logic                      ph_valid, lut_valid;
  logic [PHASE_W-1:0]        ph_trunc;
  logic signed [IN_W-1:0]    x_s1, x_s2;
  logic signed [TRIG_W-1:0]  cos_v, nsin_v;

  nco_dither_lfsr #(.W(LFSR_W), .SEED(LFSR_SEED), .TAPS(LFSR_TAPS)) u_dither (
    .clk(clk), .rst(rst), .advance(in_valid), .state(lfsr_state)
  );

  nco_phase_acc #(.ACC_W(ACC_W), .PHASE_W(PHASE_W), .DITHER_W(DITHER_W)) u_phase (
    .clk(clk), .rst(rst), .in_valid(in_valid), .phase_inc(phase_inc),
    .dither(lfsr_state[DITHER_W-1:0]), .ph_valid(ph_valid), .ph_trunc(ph_trunc)
  );

  nco_sincos_lut #(.PHASE_W(PHASE_W), .TBL_W(TBL_W), .MAG_W(MAG_W)) u_lut (
    .clk(clk), .rst(rst), .in_valid(ph_valid), .phase(ph_trunc),
    .lut_valid(lut_valid), .cos_o(cos_v), .nsin_o(nsin_v)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      x_s1 <= '0;
      x_s2 <= '0;
    end else begin
      if (in_valid) x_s1 <= in_x;
      if (ph_valid) x_s2 <= x_s1;
    end
  end

  nco_cplx_mult #(.IN_W(IN_W), .TRIG_W(TRIG_W), .OUT_W(OUT_W), .SHIFT(SHIFT)) u_mix (
    .clk(clk), .rst(rst), .in_valid(lut_valid), .x(x_s2), .cos_v(cos_v), .nsin_v(nsin_v),
    .out_valid(out_valid), .out_i(out_i), .out_q(out_q)
  );

  logic [LATENCY-1:0] vhist;
  always_ff @(posedge clk) begin
    if (rst) vhist <= '0;
    else     vhist <= {vhist[LATENCY-2:0], in_valid};
  end

  assert_latency_R2: assert property (@(posedge clk) disable iff (rst)
    out_valid == vhist[LATENCY-1]);

endmodule

// File: tb/tb_ddc_nco_mixer.sv
module tb_ddc_nco_mixer;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic               in_valid = 1'b0;
  logic signed [18:0] in_x = '0;
  logic [31:0]        phase_inc = '0;
  logic               out_valid;
  logic signed [19:0] out_i, out_q;

  always #10 clk = ~clk;  // 50 MHz

  ddc_nco_mixer dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_x(in_x), .phase_inc(phase_inc),
    .out_valid(out_valid), .out_i(out_i), .out_q(out_q)
  );

  typedef struct {
    int     ei;
    int     eq;
    int     x;
    longint issue;
    string  tag;
  } exp_t;

  exp_t        expq[$];
  int          checks = 0;
  int          errors = 0;
  longint      cyc = 0;
  logic [31:0] m_acc = '0;
  logic [15:0] m_lfsr = 16'hACE1;
  int          last_i = 0, last_q = 0;
  bit          done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic int tab(int k);
    real a;
    a = 131072.0 * $sin(real'(k) * 3.14159265358979323846 / 512.0);
    return int'($floor(a + 0.5));
  endfunction

  function automatic int trig(int quad, int idx);
    int m;
    m = (quad == 1 || quad == 3) ? tab(256 - idx) : tab(idx);
    return (quad >= 2) ? -m : m;
  endfunction

  function automatic int to_q19(longint p);
    real r;
    r = $floor(real'(p) / 65536.0 + 0.5);
    if (r > 524287.0) return 524287;
    if (r < -524288.0) return -524288;
    return int'(r);
  endfunction

  function automatic logic [15:0] lfsr_step(logic [15:0] s);
    logic nb;
    nb = s[10] ^ s[12] ^ s[13] ^ s[15];
    return {s[14:0], nb};
  endfunction

  function automatic int iabs(int v);
    return (v < 0) ? -v : v;
  endfunction

  task automatic check(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: %s actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // called right after a falling edge
  task automatic send(int x, logic [31:0] inc, string tag);
    exp_t        e;
    logic [31:0] dph;
    logic [17:0] qp;
    int          quad, idx;
    dph  = m_acc + {18'd0, m_lfsr[13:0]};
    qp   = dph[31:14];
    quad = int'(qp[17:16]);
    idx  = int'(qp[15:8]);
    e.x     = x;
    e.ei    = to_q19(longint'(x) * longint'(trig((quad + 1) % 4, idx)));
    e.eq    = to_q19(longint'(x) * longint'(-trig(quad, idx)));
    e.issue = cyc;
    e.tag   = tag;
    expq.push_back(e);
    in_valid  = 1'b1;
    in_x      = 19'(x);
    phase_inc = inc;
    @(negedge clk);
    in_valid = 1'b0;
    m_acc    = m_acc + inc;
    m_lfsr   = lfsr_step(m_lfsr);
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R1", "out_valid in reset", int'(out_valid), 0);
    check(out_i == 0 && out_q == 0, "R1", "outputs in reset", int'(out_i) + int'(out_q), 0);
    rst    = 1'b0;
    m_acc  = '0;
    m_lfsr = 16'hACE1;
    last_i = 0;
    last_q = 0;
  endtask

  // Output monitor: sampled on the falling edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      if (out_valid) begin
        if (expq.size() == 0) begin
          check(0, "R2", "unexpected out_valid", 1, 0);
        end else begin
          exp_t e;
          int   tol;
          e   = expq.pop_front();
          tol = 1 + iabs(e.x) / 65536;
          check(cyc == e.issue + 3, "R2", "latency", int'(cyc - e.issue), 3);
          check(iabs(int'(out_i) - e.ei) <= tol, e.tag, "I", int'(out_i), e.ei);
          check(iabs(int'(out_q) - e.eq) <= tol, e.tag, "Q", int'(out_q), e.eq);
          last_i = int'(out_i);
          last_q = int'(out_q);
        end
      end else begin
        check(int'(out_i) == last_i && int'(out_q) == last_q, "R8", "hold while idle",
              int'(out_i), last_i);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish, actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    @(negedge clk);
    do_reset();

    // R7 / R5: quarter-turn steps, full-scale negative input
    for (int n = 0; n < 8; n++) send(-262144, 32'h4000_0000, "R7");
    send(262143, 32'h0, "R5");
    idle(5);

    // R4: dither carry into table index right after reset
    do_reset();
    send(262143, 32'h003F_FFFF, "R1");
    send(262143, 32'h0, "R4");
    send(262143, 32'h0, "R4");
    idle(5);

    // R6: default tuning, back-to-back random input
    for (int n = 0; n < 400; n++)
      send(int'($urandom_range(0, 524287)) - 262144, 32'd894513835, "R6");

    // R3 / R8: random steps with idle gaps
    for (int n = 0; n < 400; n++) begin
      send(int'($urandom_range(0, 524287)) - 262144, 32'($urandom), "R3");
      idle(int'($urandom_range(0, 3)));
    end

    // R7: extremes at random phases
    for (int n = 0; n < 100; n++)
      send((n % 2 == 0) ? -262144 : 262143, 32'($urandom), "R7");

    idle(6);
    check(expq.size() == 0, "R2", "outputs missing", expq.size(), 0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule